// File: doc/BRIEF.md
# Grayscale PWM Engine with Blanking

This block turns per-channel 12-bit brightness codes into on/off enables for sixteen LED channels. All channels share one counter that advances on a dedicated grayscale clock. A cycle does not run freely. It is armed when the blank input goes low, and it runs once up to full scale. It then parks with every channel off until blank is raised and lowered again. Blank also acts as an immediate kill: while it is high every enable is low and the counter sits at zero, whether or not the clock is running.

A controller keeps the packed 192-bit brightness image at the block's input and may change it at any time. The channel compare always uses the image as it currently stands. A one-cycle completion pulse tells the controller when the cycle has finished, so that it knows when new data can be loaded without disturbing a running cycle.

Top module: `gs_pwm_engine`

## Requirements
- R1: While `blank` is high, every bit of `chan_on` is 0 and the counter is zero. This takes effect as soon as `blank` rises, without waiting for a clock edge.
- R2: At the first rising edge of `gs_clk` after `blank` falls, the counter becomes 1 and every channel whose code is nonzero turns on.
- R3: A channel whose code G lies between 1 and 4094 stays on for exactly G clock periods. It turns off at the edge where the counter leaves the value G.
- R4: The counter stops at 4095. At the edge where it reaches that value, all channels turn off, and they stay off with the counter held until `blank` is raised.
- R5: `cycle_done` is high for exactly one clock period. That period starts at the 4095th edge after `blank` falls. A cycle cut short by `blank` gives no pulse.
- R6: A channel whose code is 0 stays off for the whole cycle.
- R7: Raising `blank` part way through a cycle cuts every channel's on-time short at that point. The next fall of `blank` starts a fresh cycle from a count of zero.
- R8: The channel compare uses the current image. Raising a channel's code above the present count part way through a cycle lengthens its on-time to the new code. Lowering it below the present count leaves the channel on until the counter stops.
- R9: Channel n takes its code from `gs_image[12n+11:12n]` and drives `chan_on[n]`, so channel 15 occupies bits 191:180.
- R10: While `rst_n` is low, `chan_on` and `cycle_done` are 0, without regard to the clock.
- R11: A channel whose code is 4095 is on for 4094 clock periods and is switched off by the counter stopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gs_clk | input | 1 | Grayscale counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank | input | 1 | Asynchronous force-off and counter clear, active high |
| gs_image | input | 192 | Packed per-channel brightness codes, channel 15 in the top bits |
| chan_on | output | 16 | Per-channel enable, 1 means the channel sinks current |
| cycle_done | output | 1 | One-period pulse when the counter reaches full scale |

## Verification
The bound checker checks several rules on every clock. While blank is high, the outputs are zero and the counter is cleared. The counter steps by exactly one until it stops. After the first edge, the enable pattern equals the set of nonzero codes. Once full scale is reached, the counter holds with all channels off. The done pulse appears only on the step into full scale. Rules that depend on the history of the cycle can only be shown by the bench's scenarios: each channel's exact on-time, the effect of a mid-cycle code change in either direction, truncation by an early blank followed by a clean restart, and the lane mapping of the packed image.

// File: rtl/gs_pwm_pkg.sv
`timescale 1ns/1ps
package gs_pwm_pkg;
    parameter int unsigned CHAN_COUNT_DEF = 16;
    parameter int unsigned LEVEL_W_DEF    = 12;
endpackage

// File: rtl/gs_counter.sv
`timescale 1ns/1ps
// Shared grayscale counter: counts from zero after clear, halts at full scale.
module gs_counter #(
    parameter int unsigned LEVEL_W = gs_pwm_pkg::LEVEL_W_DEF
) (
    input  logic               clk,
    input  logic               clr,
    output logic [LEVEL_W-1:0] count_o,
    output logic               first_o,
    output logic               stop_o,
    output logic               done_o
);
    localparam logic [LEVEL_W-1:0] FULL = '1;
    localparam logic [LEVEL_W-1:0] NEAR = FULL - 1'b1;

    typedef struct packed {
        logic [LEVEL_W-1:0] cnt;
        logic               done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != FULL) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.done = (st_q.cnt == NEAR);
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign first_o = (st_q.cnt == '0);
    assign stop_o  = (st_q.cnt >= NEAR);
    assign done_o  = st_q.done;
endmodule

// File: rtl/gs_channel.sv
`timescale 1ns/1ps
// One channel's enable: set at cycle start when the code is nonzero,
// cleared when the code equals the count, forced off at full scale.
module gs_channel #(
    parameter int unsigned LEVEL_W = gs_pwm_pkg::LEVEL_W_DEF
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [LEVEL_W-1:0] level_i,
    input  logic [LEVEL_W-1:0] count_i,
    input  logic               first_i,
    input  logic               stop_i,
    output logic               on_o
);
    typedef struct packed {
        logic on;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_i) begin
            st_d.on = 1'b0;
        end else if (first_i) begin
            st_d.on = (level_i != '0);
        end else if (level_i == count_i) begin
            st_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign on_o = st_q.on;
endmodule

// File: rtl/gs_pwm_engine.sv
`timescale 1ns/1ps
module gs_pwm_engine #(
    parameter int unsigned CHANNELS = gs_pwm_pkg::CHAN_COUNT_DEF,
    parameter int unsigned LEVEL_W  = gs_pwm_pkg::LEVEL_W_DEF
) (
    input  logic                          gs_clk,
    input  logic                          rst_n,
    input  logic                          blank,
    input  logic [CHANNELS*LEVEL_W-1:0]   gs_image,
    output logic [CHANNELS-1:0]           chan_on,
    output logic                          cycle_done
);
    logic               clr_w;
    logic [LEVEL_W-1:0] cnt_w;
    logic               first_w;
    logic               stop_w;

    // blank and reset share one asynchronous clear path
    assign clr_w = blank | ~rst_n;

    gs_counter #(.LEVEL_W(LEVEL_W)) u_counter (
        .clk     (gs_clk),
        .clr     (clr_w),
        .count_o (cnt_w),
        .first_o (first_w),
        .stop_o  (stop_w),
        .done_o  (cycle_done)
    );

    for (genvar n = 0; n < CHANNELS; n++) begin : g_lane
        gs_channel #(.LEVEL_W(LEVEL_W)) u_channel (
            .clk     (gs_clk),
            .clr     (clr_w),
            .level_i (gs_image[n*LEVEL_W +: LEVEL_W]),
            .count_i (cnt_w),
            .first_i (first_w),
            .stop_i  (stop_w),
            .on_o    (chan_on[n])
        );
    end
endmodule

// File: rtl/gs_pwm_checker.sv
`timescale 1ns/1ps
module gs_pwm_checker #(
    parameter int unsigned CHANNELS = gs_pwm_pkg::CHAN_COUNT_DEF,
    parameter int unsigned LEVEL_W  = gs_pwm_pkg::LEVEL_W_DEF
) (
    input logic                        gs_clk,
    input logic                        rst_n,
    input logic                        blank,
    input logic [CHANNELS*LEVEL_W-1:0] gs_image,
    input logic [CHANNELS-1:0]         chan_on,
    input logic                        cycle_done,
    input logic [LEVEL_W-1:0]          count
);
    localparam logic [LEVEL_W-1:0] FULL = '1;

    function automatic logic [CHANNELS-1:0] nz_mask(input logic [CHANNELS*LEVEL_W-1:0] img);
        logic [CHANNELS-1:0] m;
        for (int k = 0; k < CHANNELS; k++) begin
            m[k] = (img[k*LEVEL_W +: LEVEL_W] != '0);
        end
        return m;
    endfunction

    a_r1_blank_clears: assert property (@(posedge gs_clk) disable iff (!rst_n)
        blank |-> (chan_on == '0 && count == '0));

    a_r2_first_edge_mask: assert property (@(posedge gs_clk) disable iff (!rst_n || blank)
        (count == '0) |=> (count == 1 && chan_on == nz_mask($past(gs_image))));

    a_r3_count_steps: assert property (@(posedge gs_clk) disable iff (!rst_n || blank)
        (count != FULL) |=> (count == $past(count) + 1'b1));

    a_r4_saturate_hold: assert property (@(posedge gs_clk) disable iff (!rst_n || blank)
        (count == FULL) |=> (count == FULL && chan_on == '0 && !cycle_done));

    a_r5_done_at_top: assert property (@(posedge gs_clk) disable iff (!rst_n || blank)
        cycle_done |-> (count == FULL && $past(count) == FULL - 1'b1));
endmodule

bind gs_pwm_engine gs_pwm_checker #(.CHANNELS(CHANNELS), .LEVEL_W(LEVEL_W)) u_gs_pwm_checker (
    .gs_clk     (gs_clk),
    .rst_n      (rst_n),
    .blank      (blank),
    .gs_image   (gs_image),
    .chan_on    (chan_on),
    .cycle_done (cycle_done),
    .count      (cnt_w)
);

// File: tb/gs_pwm_engine_bench.sv
`timescale 1ns/1ps
module gs_pwm_engine_bench;
    localparam int CH   = 16;
    localparam int W    = 12;
    localparam int TOPV = 4095;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blank = 1'b1;
    logic [CH*W-1:0]   img = '0;
    logic [CH-1:0]     chan_on;
    logic              done;

    always #2 clk = ~clk;

    gs_pwm_engine u_gs_pwm_engine (
        .gs_clk     (clk),
        .rst_n      (rst_n),
        .blank      (blank),
        .gs_image   (img),
        .chan_on    (chan_on),
        .cycle_done (done)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R10";
    bit    finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model, stepped on each rising edge
    int            m_cnt = 0;
    bit [CH-1:0]   m_on = '0;
    bit            m_done = 0;

    always @(posedge clk) begin
        int prev;
        int code;
        if (!rst_n || blank) begin
            m_cnt = 0; m_on = '0; m_done = 0;
        end else begin
            prev = m_cnt;
            if (m_cnt < TOPV) m_cnt = m_cnt + 1;
            m_done = (m_cnt == TOPV) && (prev != TOPV);
            for (int n = 0; n < CH; n++) begin
                code = int'(img[n*W +: W]);
                if (m_cnt == TOPV)   m_on[n] = 1'b0;
                else if (prev == 0)  m_on[n] = (code != 0);
                else if (code == prev) m_on[n] = 1'b0;
            end
        end
        #1;
        if (!finished) begin
            chk(phase, "model chan_on", int'(chan_on), int'(m_on));
            chk(phase, "model cycle_done", int'(done), int'(m_done));
        end
    end

    int on_cnt[CH];
    int done_cnt;
    int done_at;
    int edge_no;

    task automatic clear_stats();
        for (int n = 0; n < CH; n++) on_cnt[n] = 0;
        done_cnt = 0; done_at = -1; edge_no = 0;
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            edge_no++;
            for (int n = 0; n < CH; n++) if (chan_on[n]) on_cnt[n]++;
            if (done) begin done_cnt++; done_at = edge_no; end
        end
    endtask

    task automatic set_ch(input int n, input int v);
        img[n*W +: W] = W'(v);
    endtask

    task automatic start_cycle();
        @(negedge clk); blank = 1'b0;
        clear_stats();
    endtask

    task automatic raise_blank();
        @(negedge clk); blank = 1'b1;
    endtask

    function automatic int expect_on(input int code);
        if (code == 0) return 0;
        if (code >= TOPV - 1) return TOPV - 1;
        return code;
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int codes[CH];
        clear_stats();
        // R10: reset holds outputs off even with blank low and data present
        blank = 1'b0;
        for (int n = 0; n < CH; n++) set_ch(n, 5);
        run(3);
        chk("R10", "chan_on in reset", int'(chan_on), 0);
        chk("R10", "cycle_done in reset", int'(done), 0);
        @(negedge clk); blank = 1'b1; rst_n = 1'b1;

        // R1: blank high keeps all off while clock runs
        phase = "R1";
        run(5);
        chk("R1", "chan_on under blank", int'(chan_on), 0);

        // R2 R3 R6 R11 R9: mixed codes
        phase = "R3";
        for (int n = 0; n < CH; n++) codes[n] = n * 251;
        codes[0] = 0; codes[1] = 1; codes[14] = 4094; codes[15] = 4095;
        for (int n = 0; n < CH; n++) set_ch(n, codes[n]);
        start_cycle();
        run(1);
        chk("R2", "mask after first edge", int'(chan_on), 16'hFFFE);
        run(TOPV + 9);
        for (int n = 0; n < CH; n++)
            chk(n == 0 ? "R6" : (n == 15 ? "R11" : "R3"), $sformatf("on-time ch%0d", n),
                on_cnt[n], expect_on(codes[n]));
        chk("R5", "done pulses", done_cnt, 1);
        chk("R5", "done edge", done_at, TOPV);
        chk("R4", "chan_on after stop", int'(chan_on), 0);
        chk("R4", "done after stop", int'(done), 0);
        raise_blank();
        run(2);
        chk("R1", "chan_on blank again", int'(chan_on), 0);

        // R7: early blank truncates, restart is clean
        phase = "R7";
        for (int n = 0; n < CH; n++) set_ch(n, 100);
        start_cycle();
        run(40);
        raise_blank();
        run(3);
        chk("R7", "chan_on after early blank", int'(chan_on), 0);
        chk("R7", "truncated on-time ch7", on_cnt[7], 40);
        chk("R5", "no done on truncation", done_cnt, 0);
        start_cycle();
        run(TOPV + 2);
        chk("R7", "restart on-time ch7", on_cnt[7], 100);
        chk("R7", "restart on-time ch12", on_cnt[12], 100);
        chk("R5", "done after restart", done_cnt, 1);
        raise_blank();

        // R8: mid-cycle code change, up and down
        phase = "R8";
        img = '0;
        set_ch(2, 10); set_ch(3, 10);
        start_cycle();
        run(5);
        @(negedge clk); set_ch(2, 20); set_ch(3, 3);
        run(TOPV + 5);
        chk("R8", "raised code on-time", on_cnt[2], 20);
        chk("R8", "lowered code on-time", on_cnt[3], TOPV - 1);
        raise_blank();

        // R9: lane mapping, single channel at each end
        phase = "R9";
        img = '0; set_ch(15, 1);
        start_cycle();
        run(1);
        chk("R9", "top lane alone", int'(chan_on), 16'h8000);
        run(1);
        chk("R9", "top lane off after one", int'(chan_on), 0);
        raise_blank();
        img = '0; img[11:0] = 12'd2;
        start_cycle();
        run(1);
        chk("R9", "bottom lane alone", int'(chan_on), 16'h0001);
        run(2);
        chk("R9", "bottom lane on-time", on_cnt[0], 2);
        raise_blank();
        run(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule